// File: doc/BRIEF.md
# Two-Wire Command and Status Slave for a Quad Power Switch

This block is the serial front end of a four-channel power switch controller. It follows a two-wire bus (clock and data lines with an open-drain data return) in the system clock domain. It recognises START and STOP conditions and answers one 7-bit device address. Two fixed upper bits come from a parameter, and the lower five come from strap inputs. No register pointer exists: a write carries a command byte and, if wanted, a configuration byte. A read returns two status bytes in a fixed sequence.

Write data is parked in shadow storage and reaches the outputs only when the STOP condition arrives. One commit therefore updates the command and configuration outputs together. At that same commit, the block can issue a single-cycle request that clears the sticky channel faults, which are kept outside this block. The data line is driven only through an output-enable, where 1 pulls the wire low.

Top module: `pwr_twi_slave`

## Requirements
- R1: The device address is {0,1,addr_pins_i[4:0]}, MSB first, followed by a direction bit (1 = read). On a match, the slave drives the data line low (sda_oe_o=1) during the ninth clock. On a mismatch, it does not acknowledge, and the rest of the transfer up to the next START or STOP has no effect.
- R2: The first data byte of a write is acknowledged and becomes ctrl_o. Bits 3:0 enable the switches of channels 1 to 4 (bit 0 = channel 1), and bits 7:4 enable their relays. A second data byte is acknowledged and becomes setup_o.
- R3: ctrl_o and setup_o change only in the clock cycle after a STOP condition is detected. Data still in flight leaves them untouched.
- R4: A write that ends after the command byte leaves setup_o at its previous value.
- R5: When a committed configuration byte has bit 0 set, fault_clr_o pulses high for exactly one cycle at the commit. In all other cases it stays low, including a command-only write.
- R6: The first byte of a read is {3'b000, 1'b1, pgood_i[3:0]}, sent MSB first.
- R7: The second byte of a read is {open_i[3:0], short_i[3:0]}, sent MSB first.
- R8: When the master answers a read byte with NACK, the slave stops driving the data line until the next START.
- R9: After a synchronous reset, ctrl_o and setup_o are 0x00, and sda_oe_o and fault_clr_o are low.
- R10: A repeated START discards any write data that has not yet been committed.
- R11: Write bytes after the second one are not acknowledged and are ignored. Read bytes after the second one return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_pins_i | input | 5 | Strap bits for the low address bits |
| pgood_i | input | 4 | Per-channel power-good |
| short_i | input | 4 | Per-channel short-circuit fault flags |
| open_i | input | 4 | Per-channel open-circuit fault flags |
| ctrl_o | output | 8 | Committed command byte |
| setup_o | output | 8 | Committed configuration byte |
| fault_clr_o | output | 1 | One-cycle fault-clear request |

## Verification
The bench builds the block with its default parameters: a two-stage line synchroniser, the fixed upper address bits 01, and strap value 10110. The strap value gives write address 0x6C and read address 0x6D, and 0x6E serves as the nearby address that must not match. The bus bit time is forty system clocks, which is well beyond the synchroniser latency. That margin lets the bench test repeated START, a third write byte, a third read byte and an early NACK at exact bit positions.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W   = 8;
  localparam int PORTS    = 4;
  localparam int WR_SLOTS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } link_state_t;

  // status byte for read slot idx; slots past the second return all ones
  function automatic logic [BYTE_W-1:0] status_byte(
    input logic [1:0]       idx,
    input logic [PORTS-1:0] pg,
    input logic [PORTS-1:0] sc,
    input logic [PORTS-1:0] oc
  );
    case (idx)
      2'd0:    status_byte = {3'b000, 1'b1, pg};
      2'd1:    status_byte = {oc, sc};
      default: status_byte = '1;
    endcase
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s, sda_s;

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
      for (int s = 1; s < STAGES; s++) begin
        scl_pipe[s] <= scl_pipe[s-1];
        sda_pipe[s] <= sda_pipe[s-1];
      end
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_link_fsm.sv
module twi_link_fsm
  import twi_pkg::*;
#(
  parameter logic [1:0] ADDR_HI = 2'b01,
  parameter int         PIN_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [PIN_W-1:0]  addr_pins,
  input  logic [PORTS-1:0]  pgood,
  input  logic [PORTS-1:0]  short_f,
  input  logic [PORTS-1:0]  open_f,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [1:0]        wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  link_state_t       state;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-2:0] tx_rest;
  logic [CNT_W-1:0]  bit_cnt;
  logic              is_addr, rd_mode, m_ack;
  logic [1:0]        data_idx, rd_idx;
  logic              addr_hit;
  logic [1:0]        load_idx;
  logic [BYTE_W-1:0] load_byte;

  assign addr_hit = (rx_sh[BYTE_W-1:1] == {ADDR_HI, addr_pins});

  always_comb begin
    if (state == ST_ACK)      load_idx = 2'd0;
    else if (rd_idx == 2'd2)  load_idx = 2'd2;
    else                      load_idx = rd_idx + 2'd1;
    load_byte = status_byte(load_idx, pgood, short_f, open_f);
  end

  always_ff @(posedge clk) begin
    wr_valid <= 1'b0;
    if (rst) begin
      state    <= ST_IDLE;
      sda_oe   <= 1'b0;
      rx_sh    <= '0;
      tx_rest  <= '0;
      bit_cnt  <= '0;
      is_addr  <= 1'b0;
      rd_mode  <= 1'b0;
      m_ack    <= 1'b0;
      data_idx <= '0;
      rd_idx   <= '0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else if (bus_start) begin
      state    <= ST_RX;
      sda_oe   <= 1'b0;
      bit_cnt  <= '0;
      is_addr  <= 1'b1;
      data_idx <= '0;
    end else if (bus_stop) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && bit_cnt != CNT_W'(BYTE_W)) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
            bit_cnt <= '0;
            if (is_addr) begin
              is_addr <= 1'b0;
              rd_mode <= rx_sh[0];
              if (addr_hit) begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end else if (data_idx < 2'(WR_SLOTS)) begin
              sda_oe   <= 1'b1;
              wr_valid <= 1'b1;
              wr_idx   <= data_idx;
              wr_data  <= rx_sh;
              data_idx <= data_idx + 2'd1;
              state    <= ST_ACK;
            end else begin
              state <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              tx_rest <= load_byte[BYTE_W-2:0];
              sda_oe  <= ~load_byte[BYTE_W-1];
              rd_idx  <= load_idx;
              bit_cnt <= '0;
              state   <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              sda_oe  <= ~tx_rest[BYTE_W-2];
              tx_rest <= {tx_rest[BYTE_W-3:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack) begin
              tx_rest <= load_byte[BYTE_W-2:0];
              sda_oe  <= ~load_byte[BYTE_W-1];
              rd_idx  <= load_idx;
              bit_cnt <= '0;
              state   <= ST_TX;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // the data line may only move right after a clock fall or a bus condition
  assert_oe_moves_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || bus_start || bus_stop));

  // a STOP always leaves the data line released
  assert_release_after_stop_R8: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> !sda_oe);
endmodule

// File: rtl/twi_shadow_regs.sv
module twi_shadow_regs
  import twi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              wr_valid,
  input  logic [1:0]        wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] setup_q,
  output logic              clr_pulse
);
  logic [BYTE_W-1:0] sh_ctrl, sh_setup;
  logic              have_ctrl, have_setup;

  always_ff @(posedge clk) begin
    clr_pulse <= 1'b0;
    if (rst) begin
      sh_ctrl    <= '0;
      sh_setup   <= '0;
      have_ctrl  <= 1'b0;
      have_setup <= 1'b0;
      ctrl_q     <= '0;
      setup_q    <= '0;
    end else if (bus_start) begin
      have_ctrl  <= 1'b0;
      have_setup <= 1'b0;
    end else if (bus_stop) begin
      if (have_ctrl) ctrl_q <= sh_ctrl;
      if (have_setup) begin
        setup_q   <= sh_setup;
        clr_pulse <= sh_setup[0];
      end
      have_ctrl  <= 1'b0;
      have_setup <= 1'b0;
    end else if (wr_valid) begin
      if (wr_idx == 2'd0) begin
        sh_ctrl   <= wr_data;
        have_ctrl <= 1'b1;
      end else begin
        sh_setup   <= wr_data;
        have_setup <= 1'b1;
      end
    end
  end

  assert_commit_at_stop_R3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ctrl_q) || !$stable(setup_q)) |-> $past(bus_stop));

  assert_clear_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |=> !clr_pulse);

  assert_clear_after_stop_R5: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |-> $past(bus_stop));

  assert_two_slots_only_R11: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_idx < 2'(WR_SLOTS)));
endmodule

// File: rtl/pwr_twi_slave.sv
module pwr_twi_slave
  import twi_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] ADDR_HI     = 2'b01,
  parameter int         PIN_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [PIN_W-1:0]  addr_pins_i,
  input  logic [PORTS-1:0]  pgood_i,
  input  logic [PORTS-1:0]  short_i,
  input  logic [PORTS-1:0]  open_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] setup_o,
  output logic              fault_clr_o
);
  logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              wr_valid;
  logic [1:0]        wr_idx;
  logic [BYTE_W-1:0] wr_data;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  twi_link_fsm #(.ADDR_HI(ADDR_HI), .PIN_W(PIN_W)) u_link (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .addr_pins (addr_pins_i),
    .pgood     (pgood_i),
    .short_f   (short_i),
    .open_f    (open_i),
    .sda_oe    (sda_oe_o),
    .wr_valid  (wr_valid),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  twi_shadow_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .wr_valid  (wr_valid),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .ctrl_q    (ctrl_o),
    .setup_q   (setup_o),
    .clr_pulse (fault_clr_o)
  );
endmodule

// File: tb/pwr_twi_slave_tb_top.sv
module pwr_twi_slave_tb_top;
  localparam int Q = 10;
  localparam logic [4:0] PINS     = 5'b10110;
  localparam logic [7:0] WR_ADDR  = 8'h6C;
  localparam logic [7:0] RD_ADDR  = 8'h6D;
  localparam logic [7:0] BAD_ADDR = 8'h6E;
  localparam int NV = 5;
  // len | b0 | b1 | b2 | exp ctrl | exp setup | exp clear pulses
  localparam logic [42:0] VECS [NV] = '{
    {2'd2, 8'hA5, 8'h3C, 8'h00, 8'hA5, 8'h3C, 1'b0},
    {2'd1, 8'h0F, 8'h00, 8'h00, 8'h0F, 8'h3C, 1'b0},
    {2'd2, 8'hF0, 8'h81, 8'h00, 8'hF0, 8'h81, 1'b1},
    {2'd1, 8'h5A, 8'h00, 8'h00, 8'h5A, 8'h81, 1'b0},
    {2'd3, 8'h11, 8'h22, 8'h33, 8'h11, 8'h22, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, fclr, sda_line;
  logic [7:0] ctrl, setup;
  logic [3:0] pg = 4'h0, sc = 4'h0, oc = 4'h0;
  int checks = 0, errors = 0, clr_cnt = 0;
  logic finished = 1'b0;
  logic [42:0] v;
  logic ack;
  logic [7:0] rb, prev_ctrl, prev_setup;
  int base_clr;

  assign sda_line = sda_m & ~sda_oe;
  always #2 clk = ~clk;
  always @(posedge clk) if (fclr) clr_cnt <= clr_cnt + 1;

  pwr_twi_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_pins_i(PINS), .pgood_i(pg), .short_i(sc), .open_i(oc),
    .ctrl_o(ctrl), .setup_o(setup), .fault_clr_o(fclr)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    acked = ~sda_line;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0;
    end
    tick(Q); sda_m = ~give_ack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(5); rst = 1'b0; tick(3);
    // R9 reset state
    check("R9 ctrl after reset", ctrl, 8'h00);
    check("R9 setup after reset", setup, 8'h00);
    check("R9 sda_oe after reset", sda_oe, 1'b0);
    check("R9 fault_clr after reset", fclr, 1'b0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      base_clr = clr_cnt; prev_ctrl = ctrl; prev_setup = setup;
      bus_start();
      send_byte(WR_ADDR, ack);  check("R1 address ack", ack, 1'b1);
      send_byte(v[40:33], ack); check("R2 command byte ack", ack, 1'b1);
      if (v[42:41] >= 2'd2) begin
        send_byte(v[32:25], ack); check("R2 setup byte ack", ack, 1'b1);
      end
      if (v[42:41] == 2'd3) begin
        send_byte(v[24:17], ack); check("R11 extra write byte nack", ack, 1'b0);
      end
      check("R3 ctrl held before stop", ctrl, prev_ctrl);
      check("R3 setup held before stop", setup, prev_setup);
      bus_stop(); tick(4);
      check("R2 ctrl committed", ctrl, v[16:9]);
      check("R4 setup after commit", setup, v[8:1]);
      check("R5 clear pulse count", clr_cnt - base_clr, 32'(v[0]));
    end

    // R1 address mismatch: no ack, data ignored
    base_clr = clr_cnt;
    bus_start();
    send_byte(BAD_ADDR, ack); check("R1 mismatch not acked", ack, 1'b0);
    send_byte(8'hEE, ack);    check("R1 data after mismatch not acked", ack, 1'b0);
    send_byte(8'h01, ack);
    bus_stop(); tick(4);
    check("R1 ctrl untouched by mismatch", ctrl, 8'h11);
    check("R1 setup untouched by mismatch", setup, 8'h22);

    // R10 repeated START aborts shadow data
    bus_start();
    send_byte(WR_ADDR, ack);
    send_byte(8'h77, ack);
    send_byte(8'h01, ack);
    bus_start();
    send_byte(BAD_ADDR, ack);
    bus_stop(); tick(4);
    check("R10 ctrl after aborted write", ctrl, 8'h11);
    check("R10 setup after aborted write", setup, 8'h22);
    check("R10 no clear pulse", clr_cnt - base_clr, 0);

    // R6 R7 R11 full read with three bytes
    pg = 4'hA; sc = 4'h3; oc = 4'hC;
    bus_start();
    send_byte(RD_ADDR, ack); check("R1 read address ack", ack, 1'b1);
    read_byte(1'b1, rb); check("R6 status byte one", rb, 8'h1A);
    read_byte(1'b1, rb); check("R7 status byte two", rb, 8'hC3);
    read_byte(1'b0, rb); check("R11 third read byte", rb, 8'hFF);
    bus_stop(); tick(4);

    // R8 early NACK releases the line
    pg = 4'h5;
    bus_start();
    send_byte(RD_ADDR, ack);
    read_byte(1'b0, rb); check("R6 status byte one alone", rb, 8'h15);
    read_byte(1'b0, rb); check("R8 line released after nack", rb, 8'hFF);
    bus_stop(); tick(4);
    check("R8 sda_oe idle after stop", sda_oe, 1'b0);
    check("R2 ctrl unchanged by reads", ctrl, 8'h11);

    // R9 reset after activity
    rst = 1'b1; tick(3); rst = 1'b0; tick(2);
    check("R9 ctrl cleared by reset", ctrl, 8'h00);
    check("R9 setup cleared by reset", setup, 8'h00);

    finish_run();
  end
endmodule